// File: doc/BRIEF.md
# Indexed interrupt status controller

This block collects event pulses from eight sources into raw status flags and gates them with a per-source enable mask. Software reaches it through a simple synchronous register bus. It can set or clear flags on purpose, read the raw and masked views, and read an index register. The index register names the lowest-numbered source that is both pending and enabled.

When the CPU reads the index register, the named source is acknowledged: its raw flag, and so its masked flag, drops on the clock edge that ends the read. The next read then names the next source. A bus qualifier marks reads that come from a debugger, and those reads leave all flags untouched.

A 2-bit line-mode field does three things. It turns the aggregated interrupt output off. It leaves clearing to software. Or it lets per-source acknowledge strobes from a consuming module clear the flags in hardware.

Top module: `irq_index_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, and the raw status, masked status, line mode and index all read 0. The interrupt output is low.
- R2: An event pulse on source n sets raw bit n on the next edge. If the same bit is also cleared in that cycle (clear register, index read or hardware acknowledge), the set wins.
- R3: Writing 1 to bit n of the set register (0x1120) sets raw bit n. Writing 1 to bit n of the clear register (0x1128) clears it, whether or not source n is enabled. A 0 bit in either register changes nothing, and both registers read back as 0.
- R4: The masked status (0x1118) reads raw status (0x1110) AND mask (0x1108). The mask is written through bits [7:0] of 0x1108.
- R5: The index register (0x1100) reads 0 when no masked bit is set. Otherwise it reads n+1, where n is the lowest-numbered set masked bit. Masked-off sources never appear in it.
- R6: A CPU read of the index register (debug qualifier low) that returns a non-zero value clears the raw bit of the reported source on that edge. The following read returns the next pending source, or 0.
- R7: A read of the index register with the debug qualifier high clears no status bit.
- R8: The line mode sits in bits [1:0] at 0x10E0: 0 = line off, 1 = software clears, 2 = hardware acknowledge clears. A write of 3 leaves the mode unchanged.
- R9: The interrupt output is the OR of the masked status bits while the mode is not 0, and is low while the mode is 0.
- R10: Acknowledge bit n clears raw bit n only while the mode is 2. In other modes it has no effect.
- R11: The description register (0x10FC) and every unlisted offset read as 0, and writes to them change no state. Read data is 0 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Register byte offset |
| bus_rd | input | 1 | Read strobe, data returned in the same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_dbg | input | 1 | High when the access comes from the debug interface |
| bus_rdata | output | 32 | Read data |
| evt_pulse | input | 8 | One-cycle event pulses, one per source |
| hw_ack | input | 8 | Per-source acknowledge from a consuming module |
| irq_out | output | 1 | Aggregated interrupt request |

## Verification
The index function is tried with several pending patterns:
- Sparse pending bits show that the lowest number wins.
- Pending bits present only on masked-off sources show that the mask filters the index as well as the masked status.
- Back-to-back CPU reads drain a group of sources in priority order, which tells acknowledge-on-read apart from a plain read.

Repeated debug reads of the same index separate the two read kinds. A pulse or set in the same cycle as a clear, index read or acknowledge shows whether set-over-clear holds. Acknowledge strobes sent in software mode and then in hardware mode show whether the mode gates the hardware path.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
// Shared constants for the indexed interrupt status controller.
// Assumes byte offsets on a 16-bit register bus.
package irqc_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 8;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_SW  = 2'd1,
        MODE_HW  = 2'd2
    } line_mode_e;

    localparam logic [ADDR_W-1:0] OFS_MODE = 16'h10E0;
    localparam logic [ADDR_W-1:0] OFS_DESC = 16'h10FC;
    localparam logic [ADDR_W-1:0] OFS_IDX  = 16'h1100;
    localparam logic [ADDR_W-1:0] OFS_MASK = 16'h1108;
    localparam logic [ADDR_W-1:0] OFS_RAW  = 16'h1110;
    localparam logic [ADDR_W-1:0] OFS_MSK  = 16'h1118;
    localparam logic [ADDR_W-1:0] OFS_SET  = 16'h1120;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 16'h1128;
endpackage

// File: rtl/irqc_status_bank.sv
`timescale 1ns/1ps
// Raw status flags, one per source. A set request beats a clear request
// for the same bit in the same cycle. Assumes synchronous active-low reset.
module irqc_status_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] raw_q
);
    // Update flags: clear first, then apply sets so sets win.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/irqc_prio_enc.sv
`timescale 1ns/1ps
// Fixed-priority index encoder: returns 0 when idle, else lowest set bit + 1.
// Assumes N + 1 fits in IDX_W bits.
module irqc_prio_enc #(
    parameter int N     = 8,
    parameter int IDX_W = 8
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx
);
    // Scan from high to low so the lowest-numbered request is kept last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i + 1);
        end
    end
endmodule

// File: rtl/irqc_ctrl_regs.sv
`timescale 1ns/1ps
// Mask and line-mode control registers. The mask resets with all sources
// enabled; the mode resets to off and refuses the unused encoding 3.
module irqc_ctrl_regs
    import irqc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic         mode_we,
    input  logic [N-1:0] wdata_n,
    output logic [N-1:0] mask_q,
    output line_mode_e   mode_q
);
    // Mask register write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_we) mask_q <= wdata_n;
    end

    // Mode register write; encoding 3 is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else if (mode_we && (wdata_n[1:0] != 2'd3)) mode_q <= line_mode_e'(wdata_n[1:0]);
    end
endmodule

// File: rtl/irq_index_ctrl.sv
`timescale 1ns/1ps
// Indexed interrupt status controller top. It decodes the register bus,
// forms set/clear vectors for the status bank, encodes the priority index
// and acknowledges the indexed source on CPU (non-debug) reads.
// Assumes single-cycle reads with combinational read data and NUM_SRC <= 8.
module irq_index_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_dbg,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic [NUM_SRC-1:0] hw_ack,
    output logic              irq_out
);
    logic [NUM_SRC-1:0] raw_q, mask_q, mis, set_vec, clr_vec, idx_clr;
    logic [NUM_SRC-1:0] wdata_n;
    line_mode_e         mode_q;
    logic [IDX_W-1:0]   idx_cur;
    logic               cpu_idx_rd;

    assign wdata_n    = bus_wdata[NUM_SRC-1:0];
    assign mis        = raw_q & mask_q;
    assign cpu_idx_rd = bus_rd && !bus_dbg && (bus_addr == OFS_IDX);

    irqc_ctrl_regs #(.N(NUM_SRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (bus_wr && (bus_addr == OFS_MASK)),
        .mode_we (bus_wr && (bus_addr == OFS_MODE)),
        .wdata_n (wdata_n),
        .mask_q  (mask_q),
        .mode_q  (mode_q)
    );

    irqc_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .req (mis),
        .idx (idx_cur)
    );

    // One-hot acknowledge of the indexed source on a CPU index read.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ack
        assign idx_clr[g] = cpu_idx_rd && (idx_cur == IDX_W'(g + 1));
    end

    // Combine all set and clear requests for the status bank.
    always_comb begin
        set_vec = evt_pulse;
        clr_vec = idx_clr;
        if (bus_wr && (bus_addr == OFS_SET)) set_vec = set_vec | wdata_n;
        if (bus_wr && (bus_addr == OFS_CLR)) clr_vec = clr_vec | wdata_n;
        if (mode_q == MODE_HW)               clr_vec = clr_vec | hw_ack;
    end

    irqc_status_bank #(.N(NUM_SRC)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .raw_q   (raw_q)
    );

    // Read data multiplexer; zero outside a read and for unlisted offsets.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_MODE: bus_rdata = DATA_W'(mode_q);
                OFS_IDX:  bus_rdata = DATA_W'(idx_cur);
                OFS_MASK: bus_rdata = DATA_W'(mask_q);
                OFS_RAW:  bus_rdata = DATA_W'(raw_q);
                OFS_MSK:  bus_rdata = DATA_W'(mis);
                default:  bus_rdata = '0;
            endcase
        end
    end

    // Aggregated request, gated while the line is off.
    assign irq_out = (mode_q != MODE_OFF) && (|mis);
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
// Property checker for the indexed interrupt status controller.
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_dbg,
    input logic [N-1:0]      evt_pulse,
    input logic [N-1:0]      hw_ack,
    input logic              irq_out,
    input logic [N-1:0]      raw_q,
    input logic [N-1:0]      mask_q,
    input logic [1:0]        mode_q,
    input logic [IDX_W-1:0]  idx_cur
);
    AST_EVT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((raw_q & $past(evt_pulse)) == $past(evt_pulse))); // R2

    AST_SET_REG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_SET) |=>
        ((raw_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0]))); // R3

    AST_IDX_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_q & mask_q) == '0) |-> (idx_cur == '0)); // R5

    AST_CPU_READ_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_dbg && !bus_wr && bus_addr == OFS_IDX && idx_cur != '0 && evt_pulse == '0)
        |=> ($countones(raw_q) < $countones($past(raw_q)))); // R6

    AST_DBG_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_dbg && !bus_wr && bus_addr == OFS_IDX && hw_ack == '0)
        |=> ((raw_q & $past(raw_q)) == $past(raw_q))); // R7

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != 2'd3); // R8

    AST_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd0) |-> !irq_out); // R9

    AST_SW_IGNORES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd1 && !bus_rd && !bus_wr)
        |=> ((raw_q & $past(raw_q)) == $past(raw_q))); // R10
endmodule

bind irq_index_ctrl irqc_checker #(.N(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_dbg   (bus_dbg),
    .evt_pulse (evt_pulse),
    .hw_ack    (hw_ack),
    .irq_out   (irq_out),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .mode_q    (mode_q),
    .idx_cur   (idx_cur)
);

// File: tb/test_irq_index_ctrl.sv
`timescale 1ns/1ps
module test_irq_index_ctrl;
    localparam int N = 8;
    localparam logic [15:0] A_MODE = 16'h10E0, A_DESC = 16'h10FC, A_IDX = 16'h1100,
                            A_MASK = 16'h1108, A_RAW = 16'h1110, A_MSK = 16'h1118,
                            A_SET = 16'h1120, A_CLR = 16'h1128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_dbg = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] evt_pulse = '0, hw_ack = '0;
    logic        irq_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // reference state
    bit [7:0] m_raw = 8'h00;
    bit [7:0] m_mask = 8'hFF;
    int       m_mode = 0;

    always #2.5 clk = ~clk;

    irq_index_ctrl i_irq_index_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_dbg(bus_dbg),
        .bus_rdata(bus_rdata), .evt_pulse(evt_pulse), .hw_ack(hw_ack),
        .irq_out(irq_out)
    );

    function automatic int ref_idx();
        for (int i = 0; i < N; i++) if (m_raw[i] && m_mask[i]) return i + 1;
        return 0;
    endfunction

    function automatic bit [31:0] ref_read(input bit [15:0] a);
        case (a)
            A_MODE:  return 32'(m_mode);
            A_IDX:   return 32'(ref_idx());
            A_MASK:  return 32'(m_mask);
            A_RAW:   return 32'(m_raw);
            A_MSK:   return 32'(m_raw & m_mask);
            default: return 32'h0;
        endcase
    endfunction

    // One bus cycle: drive, compare outputs against the model, advance model.
    task automatic step(input string tag, input bit [15:0] a, input bit rd, input bit wr,
                        input bit [31:0] wd, input bit dbg, input bit [7:0] ev, input bit [7:0] ak);
        bit [31:0] exp_rd;
        bit        exp_irq;
        bit [7:0]  setv, clrv;
        int        ix;
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; bus_dbg = dbg;
        evt_pulse = ev; hw_ack = ak;
        #1;
        exp_rd  = rd ? ref_read(a) : 32'h0;
        exp_irq = (m_mode != 0) && ((m_raw & m_mask) != 0);
        compared++;
        if (bus_rdata !== exp_rd) begin
            mismatched++;
            $display("FAIL %s rdata at %h: actual %h expected %h", tag, a, bus_rdata, exp_rd);
        end
        compared++;
        if (irq_out !== exp_irq) begin
            mismatched++;
            $display("FAIL R9 (%s) irq_out: actual %b expected %b", tag, irq_out, exp_irq);
        end
        ix   = ref_idx();
        setv = ev | ((wr && a == A_SET) ? wd[7:0] : 8'h00);
        clrv = ((wr && a == A_CLR) ? wd[7:0] : 8'h00) | ((m_mode == 2) ? ak : 8'h00);
        if (rd && !dbg && a == A_IDX && ix != 0) clrv[ix-1] = 1'b1;
        m_raw = (m_raw & ~clrv) | setv;
        if (wr && a == A_MASK) m_mask = wd[7:0];
        if (wr && a == A_MODE && wd[1:0] != 2'd3) m_mode = int'(wd[1:0]);
    endtask

    task automatic rd_(input string tag, input bit [15:0] a);
        step(tag, a, 1'b1, 1'b0, 32'h0, 1'b0, 8'h00, 8'h00);
    endtask
    task automatic wr_(input string tag, input bit [15:0] a, input bit [31:0] d);
        step(tag, a, 1'b0, 1'b1, d, 1'b0, 8'h00, 8'h00);
    endtask
    task automatic ev_(input string tag, input bit [7:0] e);
        step(tag, 16'h0, 1'b0, 1'b0, 32'h0, 1'b0, e, 8'h00);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        rd_("R1", A_MASK); rd_("R1", A_RAW); rd_("R1", A_MSK);
        rd_("R1", A_MODE); rd_("R1", A_IDX);
        // R8 software mode, R2 events, R5 index, R6 drain on CPU reads
        wr_("R8", A_MODE, 32'h1); rd_("R8", A_MODE);
        ev_("R2", 8'h28); rd_("R2", A_RAW);
        rd_("R5", A_IDX); rd_("R6", A_IDX); rd_("R6", A_IDX); rd_("R6", A_RAW);
        // R4 mask filtering, R5 masked sources never indexed
        wr_("R4", A_MASK, 32'h0F); ev_("R2", 8'hF0);
        rd_("R4", A_MSK); rd_("R5", A_IDX); rd_("R4", A_RAW);
        // R3 clear of a masked bit, zeros ignored, set register
        wr_("R3", A_CLR, 32'h10); rd_("R3", A_RAW);
        wr_("R3", A_CLR, 32'h00); wr_("R3", A_SET, 32'h00); rd_("R3", A_RAW);
        wr_("R3", A_SET, 32'h05); rd_("R3", A_RAW); rd_("R5", A_IDX);
        rd_("R3", A_SET); rd_("R3", A_CLR);
        // R7 debug reads do not acknowledge
        step("R7", A_IDX, 1'b1, 1'b0, 32'h0, 1'b1, 8'h00, 8'h00);
        step("R7", A_IDX, 1'b1, 1'b0, 32'h0, 1'b1, 8'h00, 8'h00);
        rd_("R7", A_RAW);
        // R2 set wins over clear register and over index acknowledge
        step("R2", A_CLR, 1'b0, 1'b1, 32'h01, 1'b0, 8'h01, 8'h00); rd_("R2", A_RAW);
        step("R2", A_IDX, 1'b1, 1'b0, 32'h0, 1'b0, 8'h01, 8'h00); rd_("R2", A_RAW);
        // R9 line off gates output; R8 encoding 3 ignored
        wr_("R9", A_MODE, 32'h0); rd_("R9", A_MSK);
        wr_("R8", A_MODE, 32'h3); rd_("R8", A_MODE);
        // R10 acknowledge ignored in software mode, honoured in hardware mode
        wr_("R10", A_MASK, 32'hFF); wr_("R10", A_MODE, 32'h1);
        step("R10", 16'h0, 1'b0, 1'b0, 32'h0, 1'b0, 8'h00, 8'hFF); rd_("R10", A_RAW);
        wr_("R10", A_MODE, 32'h2);
        step("R10", 16'h0, 1'b0, 1'b0, 32'h0, 1'b0, 8'h00, 8'h05); rd_("R10", A_RAW);
        step("R2", 16'h0, 1'b0, 1'b0, 32'h0, 1'b0, 8'h40, 8'h40); rd_("R2", A_RAW);
        // R11 description, unlisted offsets, strobe low
        wr_("R11", 16'h1104, 32'hFFFF_FFFF); wr_("R11", A_DESC, 32'hFF);
        rd_("R11", 16'h1104); rd_("R11", A_DESC); rd_("R11", A_RAW); rd_("R11", A_MASK);
        step("R11", A_RAW, 1'b0, 1'b0, 32'h0, 1'b0, 8'h00, 8'h00);
        // drain remaining in priority order
        for (int k = 0; k < 9; k++) rd_("R6", A_IDX);
        rd_("R6", A_RAW);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule